// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small, fully associative cache of recent page translations. Every translation request is presented here before any page table walk. A request carries a virtual page number, and the current address-space identifier comes with it. Each slot holds a virtual page number, a physical frame number and an address-space identifier. A request hits when a valid slot matches both the page number and the current identifier. On a hit the stored frame is returned, and no table access is needed. On a miss the block raises a miss indication, and an external walker later writes the translation back through the fill port.

Because each slot carries an identifier, the same virtual page can be cached for several processes at once, and a context switch needs no flush. Two flush operations are also provided. One clears every slot in a single cycle. The other clears only the slots that belong to one identifier, for retiring a single address space. A fill goes to a slot that already holds the same page and identifier if one exists. Otherwise it goes to the lowest-numbered empty slot, and if no slot is empty, to the slot named by a round-robin pointer.

Top module: `tagged_xlate_cache`

## Requirements
- R1: Each cycle with `lk_valid` high produces `rsp_valid` high in the following cycle. A cycle without a request produces `rsp_valid` low in the following cycle.
- R2: A request hits when a valid slot holds the requested page number together with `cur_asid`. `rsp_hit` is then 1, `rsp_miss` is 0 and `rsp_frame` equals the stored frame. On a miss `rsp_hit` is 0, `rsp_miss` is 1 and `rsp_frame` is 0.
- R3: A slot whose identifier differs from `cur_asid` never produces a hit, even when its page number matches.
- R4: A request is judged against the contents held before the clock edge that ends its cycle. A fill or flush in the same cycle is not visible to that request, but it is visible to requests in later cycles.
- R5: A fill that matches no valid slot on page number and identifier is written into the lowest-numbered invalid slot.
- R6: When every slot is valid and the fill matches none of them, the fill replaces the slot named by the round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last slot, only on such a replacement.
- R7: A fill whose page number and identifier match a valid slot overwrites that slot's frame in place. No second copy is created, and the pointer does not move.
- R8: A flush of one identifier invalidates every slot that carries that identifier and leaves all other slots untouched.
- R9: A full flush invalidates every slot in one cycle.
- R10: A fill presented in the same cycle as either kind of flush is discarded.
- R11: After reset every slot is invalid, so the first requests miss, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Translation request this cycle |
| lk_vpn | input | VPN_W (20) | Virtual page number to translate |
| cur_asid | input | ASID_W (8) | Identifier of the running address space |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | The response is a hit |
| rsp_miss | output | 1 | The response is a miss; the walker should be started |
| rsp_frame | output | PFN_W (20) | Translated frame number on a hit, 0 otherwise |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W (20) | Page number of the fill |
| fill_pfn | input | PFN_W (20) | Frame number of the fill |
| fill_asid | input | ASID_W (8) | Identifier of the fill |
| flush_all | input | 1 | Invalidate every slot |
| flush_id_valid | input | 1 | Invalidate the slots of one identifier |
| flush_id | input | ASID_W (8) | Identifier to flush |

## Verification
The collisions that matter are a request and a fill landing in the same cycle, and a fill landing in the same cycle as a flush. The bench provokes both with directed steps. In the first, a request and the fill of the same page share a cycle, and the request must miss while the next request to that page hits. In the second, a fill shares a cycle with a full flush and then with a one-identifier flush, and later requests show that the fill was dropped. A long pseudo-random sweep over a small pool of pages and identifiers then mixes requests, fills and flushes freely. Each response is compared with a behavioural model of the slots, empty-slot choice and pointer kept in the bench, and that model is updated after the request has been judged.

// File: rtl/xlc_pkg.sv
// Package: shared types of the tagged translation cache.
// Assumes: nothing; imported by the victim selector.
package xlc_pkg;
    // Where a fill is placed.
    typedef enum logic [1:0] {
        VSRC_REUSE = 2'd0,
        VSRC_FREE  = 2'd1,
        VSRC_EVICT = 2'd2
    } vsrc_e;
endpackage

// File: rtl/xlc_store.sv
// Module: slot storage. Holds the valid bits and the page, frame and identifier
// fields. Applies flushes and single-slot writes.
// Assumes: wr_en is already suppressed by the parent whenever a flush is active.
module xlc_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              clr_all,
    input  logic [ENTRIES-1:0] clr_sel,
    output logic [ENTRIES-1:0] valid_q,
    output logic [VPN_W-1:0]  vpn_q  [ENTRIES],
    output logic [PFN_W-1:0]  pfn_q  [ENTRIES],
    output logic [ASID_W-1:0] asid_q [ENTRIES]
);

    // Valid bits: reset, full clear, selective clear, then set on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr_all) begin
            valid_q <= '0;
        end else begin
            valid_q <= (valid_q & ~clr_sel) |
                       (wr_en ? (ENTRIES'(1) << wr_idx) : '0);
        end
    end

    // Per-slot data fields: written only when the slot is addressed.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q[g]  <= '0;
                pfn_q[g]  <= '0;
                asid_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                vpn_q[g]  <= wr_vpn;
                pfn_q[g]  <= wr_pfn;
                asid_q[g] <= wr_asid;
            end
        end
    end

    // R9: a full flush leaves no slot valid.
    a_r9_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0));

    // R5: a written slot is valid in the next cycle.
    a_r5_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> valid_q[$past(wr_idx)]);

    // R8: a selectively cleared slot is invalid in the next cycle.
    a_r8_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && clr_sel != '0) |=> ((valid_q & $past(clr_sel)) == '0));

endmodule

// File: rtl/xlc_match.sv
// Module: associative compare. Matches the request, the fill and the flush
// identifier against every slot. Returns the hit and the selected frame.
// Assumes: the storage never holds two valid slots with the same page and identifier.
module xlc_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [VPN_W-1:0]   vpn_q  [ENTRIES],
    input  logic [PFN_W-1:0]   pfn_q  [ENTRIES],
    input  logic [ASID_W-1:0]  asid_q [ENTRIES],
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic [ASID_W-1:0]  fl_asid,
    input  logic [ASID_W-1:0]  kill_asid,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ENTRIES-1:0] dup_vec,
    output logic [ENTRIES-1:0] free_vec,
    output logic [ENTRIES-1:0] kill_vec
);

    logic [ENTRIES-1:0] hit_vec;

    // Per-slot comparators for the request, the fill and the flush identifier.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]  = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
        assign dup_vec[g]  = valid_q[g] && (vpn_q[g] == fl_vpn) && (asid_q[g] == fl_asid);
        assign kill_vec[g] = asid_q[g] == kill_asid;
    end

    assign free_vec = ~valid_q;
    assign lk_hit   = |hit_vec;

    // Frame select: AND-OR mux over the one-hot hit vector.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_pfn = lk_pfn | ({PFN_W{hit_vec[i]}} & pfn_q[i]);
        end
    end

    // R7: at most one slot can match a request.
    a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: at most one slot can match a fill.
    a_r7_single_dup: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dup_vec));

endmodule

// File: rtl/xlc_victim.sv
// Module: fill placement. Picks the matching slot first, then the lowest free
// slot, then the round-robin slot. Advances the pointer only on a replacement.
// Assumes: dup_vec is at most one-hot; take is high only for a committed fill.
module xlc_victim
    import xlc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic [ENTRIES-1:0] free_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   idx,
    output vsrc_e              src
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;

    // Placement choice: a match overrides a free slot, which overrides the pointer.
    always_comb begin
        idx = rr_q;
        src = VSRC_EVICT;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                idx = IDX_W'(i);
                src = VSRC_FREE;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (dup_vec[i]) begin
                idx = IDX_W'(i);
                src = VSRC_REUSE;
            end
        end
    end

    // Round-robin pointer: steps with wrap on each committed replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (take && src == VSRC_EVICT) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // R5: the pointer is used only when nothing is free and nothing matches.
    a_r5_evict_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src == VSRC_EVICT) |-> (free_vec == '0 && dup_vec == '0));

    // R7: reusing a matching slot leaves the pointer unchanged.
    a_r7_reuse_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src == VSRC_REUSE) |=> $stable(rr_q));

endmodule

// File: rtl/tagged_xlate_cache.sv
// Module: top of the tagged translation cache. Connects storage, compare and
// placement, resolves fill/flush priority and registers the response.
// Assumes: the walker fills only after a reported miss, with a correct translation.
module tagged_xlate_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PFN_W-1:0]  rsp_frame,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              flush_all,
    input  logic              flush_id_valid,
    input  logic [ASID_W-1:0] flush_id
);
    import xlc_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic               lk_hit;
    logic [PFN_W-1:0]   lk_pfn;
    logic [ENTRIES-1:0] dup_vec, free_vec, kill_vec, clr_sel;
    logic [IDX_W-1:0]   wr_idx;
    vsrc_e              wr_src;
    logic               commit;

    // Any flush wins over a fill in the same cycle.
    assign commit  = fill_valid && !flush_all && !flush_id_valid;
    assign clr_sel = flush_id_valid ? kill_vec : '0;

    xlc_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .ASID_W(ASID_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_idx(wr_idx),
        .wr_vpn(fill_vpn), .wr_pfn(fill_pfn), .wr_asid(fill_asid),
        .clr_all(flush_all), .clr_sel(clr_sel),
        .valid_q(valid_q), .vpn_q(vpn_q), .pfn_q(pfn_q), .asid_q(asid_q)
    );

    xlc_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) u_match (
        .clk(clk), .rst_n(rst_n),
        .valid_q(valid_q), .vpn_q(vpn_q), .pfn_q(pfn_q), .asid_q(asid_q),
        .lk_vpn(lk_vpn), .lk_asid(cur_asid),
        .fl_vpn(fill_vpn), .fl_asid(fill_asid),
        .kill_asid(flush_id),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .dup_vec(dup_vec), .free_vec(free_vec), .kill_vec(kill_vec)
    );

    xlc_victim #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .dup_vec(dup_vec), .free_vec(free_vec), .take(commit),
        .idx(wr_idx), .src(wr_src)
    );

    // Response register: one cycle after the request, judged on the pre-edge contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_frame <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_miss  <= lk_valid && !lk_hit;
            rsp_frame <= (lk_valid && lk_hit) ? lk_pfn : '0;
        end
    end

    // R1: a request produces a response in the next cycle.
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R1: no request, no response in the next cycle.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R2: a response is exactly one of hit or miss.
    a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R2: a miss carries a zero frame.
    a_r2_miss_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_frame == '0));

    // R10: a fill during a flush leaves every slot invalid after a full flush.
    a_r10_flush_beats_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && fill_valid) |=> (valid_q == '0));

endmodule

// File: tb/tb_tagged_xlate_cache.sv
// Bench: directed collision steps plus a pseudo-random sweep. The results are
// compared with a behavioural slot model kept in the bench.
module tb_tagged_xlate_cache;

    localparam int N  = 8;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] cur_asid = '0;
    logic          rsp_valid, rsp_hit, rsp_miss;
    logic [PW-1:0] rsp_frame;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic          flush_all = 1'b0;
    logic          flush_id_valid = 1'b0;
    logic [AW-1:0] flush_id = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Behavioural model of the slots.
    bit          m_v    [N];
    bit [VW-1:0] m_vpn  [N];
    bit [PW-1:0] m_pfn  [N];
    bit [AW-1:0] m_asid [N];
    int          m_rr;

    always #2.5 clk = ~clk;

    tagged_xlate_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .cur_asid(cur_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_frame(rsp_frame),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
        .flush_all(flush_all), .flush_id_valid(flush_id_valid), .flush_id(flush_id)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, model the clock edge, check at the next falling edge.
    task automatic step(input string req,
                        input bit lk, input int lv, input int la,
                        input bit fv, input int fvp, input int fpf, input int fas,
                        input bit fa, input bit fi, input int fid);
        bit exp_hit;
        bit [PW-1:0] exp_frm;
        int dup, idx;
        lk_valid = lk; lk_vpn = VW'(lv); cur_asid = AW'(la);
        fill_valid = fv; fill_vpn = VW'(fvp); fill_pfn = PW'(fpf); fill_asid = AW'(fas);
        flush_all = fa; flush_id_valid = fi; flush_id = AW'(fid);
        exp_hit = 1'b0; exp_frm = '0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == VW'(lv) && m_asid[i] == AW'(la)) begin
                exp_hit = 1'b1; exp_frm = m_pfn[i];
            end
        @(posedge clk);
        if (fa) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (fi) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == AW'(fid)) m_v[i] = 1'b0;
        end else if (fv) begin
            dup = -1; idx = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == VW'(fvp) && m_asid[i] == AW'(fas)) dup = i;
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
            if (dup >= 0) idx = dup;
            else if (idx < 0) begin idx = m_rr; m_rr = (m_rr + 1) % N; end
            m_v[idx] = 1'b1; m_vpn[idx] = VW'(fvp); m_pfn[idx] = PW'(fpf); m_asid[idx] = AW'(fas);
        end
        @(negedge clk);
        check(lk ? "R1" : "R1", "rsp_valid", {31'd0, rsp_valid}, {31'd0, lk});
        if (lk) begin
            check(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, exp_hit});
            check(req, "rsp_miss", {31'd0, rsp_miss}, {31'd0, !exp_hit});
            check(req, "rsp_frame", 32'(rsp_frame), 32'(exp_frm));
        end
    endtask

    task automatic lookup(input string req, input int v, input int a);
        step(req, 1, v, a, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input string req, input int v, input int p, input int a);
        step(req, 0, 0, 0, 1, v, p, a, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_asid[i] = 0; end
        m_rr = 0;
        repeat (3) @(negedge clk);
        check("R11", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        lookup("R11", 'h123, 1);

        // R5: fill all slots for identifier 1, frames derived from the page.
        for (int k = 0; k < N; k++) fill("R5", 'h100 + k, 'h5000 + 3 * k, 1);
        for (int k = 0; k < N; k++) lookup("R2", 'h100 + k, 1);
        // R3: same pages, other identifier.
        for (int k = 0; k < N; k++) lookup("R3", 'h100 + k, 2);
        // R6: replacements walk the pointer 0,1,2...
        for (int k = 0; k < 3; k++) fill("R6", 'h200 + k, 'h7000 + k, 1);
        lookup("R6", 'h100, 1);
        lookup("R6", 'h102, 1);
        lookup("R6", 'h103, 1);
        lookup("R6", 'h202, 1);
        // R7: refill an existing translation with a new frame.
        fill("R7", 'h105, 'hABCDE, 1);
        lookup("R7", 'h105, 1);
        fill("R7", 'h300, 'h1111, 1);
        lookup("R7", 'h103, 1);
        lookup("R7", 'h300, 1);
        // R8: flush one identifier among a mix.
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < N; k++) fill("R5", 'h40 + k, 'h900 + k, (k % 2 == 0) ? 3 : 4);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
        for (int k = 0; k < N; k++) lookup("R8", 'h40 + k, (k % 2 == 0) ? 3 : 4);
        fill("R5", 'h60, 'h61, 5);
        lookup("R5", 'h60, 5);
        // R4: a request and a fill of the same page in one cycle.
        step("R4", 1, 'h77, 6, 1, 'h77, 'h7777, 6, 0, 0, 0);
        lookup("R4", 'h77, 6);
        // R4: a request during a full flush still sees the old contents.
        step("R4", 1, 'h77, 6, 0, 0, 0, 0, 1, 0, 0);
        lookup("R9", 'h77, 6);
        // R10: fills during either flush are discarded.
        step("R10", 0, 0, 0, 1, 'h88, 'h8, 7, 1, 0, 0);
        lookup("R10", 'h88, 7);
        step("R10", 0, 0, 0, 1, 'h89, 'h9, 7, 0, 1, 2);
        lookup("R10", 'h89, 7);

        // Sweep: mixed traffic over a small page and identifier pool.
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 4000; n++) begin
            int op;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op = int'(lfsr[7:0]);
            step("R2", lfsr[8], int'(lfsr[12:9]) % 12, int'(lfsr[14:13]) % 3,
                 lfsr[15], int'(lfsr[19:16]) % 12, int'(lfsr[31:20]), int'(lfsr[21:20]) % 3,
                 op == 5, op > 250, int'(lfsr[23:22]) % 3);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule